// File: doc/BRIEF.md
# Prioritized Four-Window Overlay Controller

This block decides, for every character cell of an on-screen display, whether the cell falls inside one of four rectangular background windows or inside the drop shadow of one of them. It then reports the attributes of the window that wins. Each window is described by an inclusive row range, an inclusive column range, an enable, a shadow enable, a 3-bit colour and a 2-bit shadow offset on each axis. All of these are written through a simple address/data port. The screen scanner presents cell positions on a valid/ready stream. The block returns one registered result per accepted position on a second valid/ready stream.

Window 0 has the highest priority and window 3 the lowest. A window's shadow competes at its own window's priority level, so a higher window's shadow covers a lower window's body. The result stream is a single-entry stage. A new position is accepted when the stage is empty or when its result is taken in the same cycle (`pos_ready = !out_valid || out_ready`). While `out_valid` is high and `out_ready` is low, the result stays unchanged and no position is accepted.

Register map. The data word is 8 bits.
- Addresses 4k+0, 4k+1, 4k+2 and 4k+3 hold the row start, row end, column start and column end of window k. Each value sits in the low bits of the data word.
- Address 16 holds the shadow widths, with window k at bits [2k+1:2k].
- Address 17 holds the shadow heights, packed the same way.
- Address 18+k is the attribute byte of window k: bit 0 is the enable, bit 1 is the shadow enable, and bits [4:2] are the colour {R,G,B}, with R in bit 4.

Top module: `win_overlay_ctrl`

## Requirements
- R1: A position accepted on a rising edge (`pos_valid && pos_ready`) produces `out_valid` high with its result after that same edge, which is one cycle of latency.
- R2: `pos_ready` equals `!out_valid || out_ready`. While `out_valid && !out_ready`, the result outputs and `out_valid` hold their values.
- R3: A cell is inside a window when row start ≤ row ≤ row end and column start ≤ column ≤ column end. Both bounds are inclusive.
- R4: A window whose enable (attribute bit 0) is 0, or whose start exceeds its end on either axis, matches no cell. This covers both its body and its shadow.
- R5: When several windows claim a cell, the lowest-numbered window wins. `out_idx` gives its number and `out_rgb` gives its colour.
- R6: With the shadow enable (attribute bit 1) set, the shadow of a window is the window's rectangle shifted right by its width field and down by its height field, minus the window itself. A shadow cell gives `out_shadow=1` and `out_rgb=0`.
- R7: A shadow cell claims at its window's priority. It beats the body or shadow of any lower-priority window and loses to any higher-priority window.
- R8: With the shadow enable cleared, or with both offset fields at 0, a window casts no shadow.
- R9: Writes to the register map behave as listed above. Writes to addresses 22 to 31 change nothing.
- R10: After reset, `out_valid` is 0 and every window is disabled.
- R11: A cell claimed by no window gives `out_active=0`, `out_shadow=0`, `out_rgb=0` and `out_idx=0`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register address |
| cfg_wdata | input | 8 | Register write data |
| pos_valid | input | 1 | Cell position is valid |
| pos_ready | output | 1 | Block can accept a position |
| pos_row | input | 5 | Character row of the cell |
| pos_col | input | 6 | Character column of the cell |
| out_valid | output | 1 | Result is valid |
| out_ready | input | 1 | Consumer takes the result |
| out_active | output | 1 | Cell is claimed by a window body or shadow |
| out_shadow | output | 1 | Winning claim is a shadow |
| out_rgb | output | 3 | Winning colour {R,G,B}, 0 for shadow or no claim |
| out_idx | output | 2 | Number of the winning window, 0 if none |

## Verification
The stall assertions assume that the consumer may lower `out_ready` at any time. They also assume that the producer keeps `pos_valid` and the position stable only as long as it wants them to count, since nothing is checked on the input side while `pos_ready` is low. The register-stability assertion assumes that configuration writes arrive only on clock edges with `cfg_we` defined. The stimulus drives every input at the falling edge, writes all fields of a window before enabling it, and holds `out_ready` high except in the dedicated stall scenario.

// File: rtl/win_overlay_pkg.sv
package win_overlay_pkg;
  // attribute byte layout
  localparam int ATTR_EN      = 0;
  localparam int ATTR_SEN     = 1;
  localparam int ATTR_RGB_LSB = 2;

  // per-window coordinate slots, in address order within a window
  typedef enum logic [1:0] {
    FLD_ROW_LO = 2'd0,
    FLD_ROW_HI = 2'd1,
    FLD_COL_LO = 2'd2,
    FLD_COL_HI = 2'd3
  } win_field_e;
endpackage

// File: rtl/win_overlay_regs.sv
module win_overlay_regs
  import win_overlay_pkg::*;
#(
  parameter int NWIN   = 4,
  parameter int ROW_W  = 5,
  parameter int COL_W  = 6,
  parameter int SH_W   = 2,
  parameter int RGB_W  = 3,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              we,
  input  logic [ADDR_W-1:0]                 addr,
  input  logic [DATA_W-1:0]                 wdata,
  output logic [NWIN-1:0][ROW_W-1:0]        row_lo,
  output logic [NWIN-1:0][ROW_W-1:0]        row_hi,
  output logic [NWIN-1:0][COL_W-1:0]        col_lo,
  output logic [NWIN-1:0][COL_W-1:0]        col_hi,
  output logic [NWIN-1:0][SH_W-1:0]         sh_w,
  output logic [NWIN-1:0][SH_W-1:0]         sh_h,
  output logic [NWIN-1:0]                   en,
  output logic [NWIN-1:0]                   sen,
  output logic [NWIN-1:0][RGB_W-1:0]        rgb
);
  localparam int WIN_SPAN  = NWIN * 4;
  localparam int SW_ADDR   = WIN_SPAN;
  localparam int SH_ADDR   = WIN_SPAN + 1;
  localparam int ATTR_BASE = WIN_SPAN + 2;
  localparam int MAP_END   = ATTR_BASE + NWIN;

  logic unused_wdata;
  assign unused_wdata = ^wdata;

  for (genvar k = 0; k < NWIN; k++) begin : g_win
    localparam logic [ADDR_W-1:0] A_RLO  = ADDR_W'(k*4 + int'(FLD_ROW_LO));
    localparam logic [ADDR_W-1:0] A_RHI  = ADDR_W'(k*4 + int'(FLD_ROW_HI));
    localparam logic [ADDR_W-1:0] A_CLO  = ADDR_W'(k*4 + int'(FLD_COL_LO));
    localparam logic [ADDR_W-1:0] A_CHI  = ADDR_W'(k*4 + int'(FLD_COL_HI));
    localparam logic [ADDR_W-1:0] A_ATTR = ADDR_W'(ATTR_BASE + k);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        row_lo[k] <= '0;
        row_hi[k] <= '0;
        col_lo[k] <= '0;
        col_hi[k] <= '0;
        sh_w[k]   <= '0;
        sh_h[k]   <= '0;
        en[k]     <= 1'b0;
        sen[k]    <= 1'b0;
        rgb[k]    <= '0;
      end else if (we) begin
        if (addr == A_RLO) row_lo[k] <= wdata[ROW_W-1:0];
        if (addr == A_RHI) row_hi[k] <= wdata[ROW_W-1:0];
        if (addr == A_CLO) col_lo[k] <= wdata[COL_W-1:0];
        if (addr == A_CHI) col_hi[k] <= wdata[COL_W-1:0];
        if (addr == ADDR_W'(SW_ADDR)) sh_w[k] <= wdata[k*SH_W +: SH_W];
        if (addr == ADDR_W'(SH_ADDR)) sh_h[k] <= wdata[k*SH_W +: SH_W];
        if (addr == A_ATTR) begin
          en[k]  <= wdata[ATTR_EN];
          sen[k] <= wdata[ATTR_SEN];
          rgb[k] <= wdata[ATTR_RGB_LSB +: RGB_W];
        end
      end
    end
  end

  // R9: writes outside the map leave every setting untouched
  a_r9_unmapped_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr >= ADDR_W'(MAP_END)) |=>
      $stable({row_lo, row_hi, col_lo, col_hi, sh_w, sh_h, en, sen, rgb}));
endmodule

// File: rtl/win_overlay_match.sv
module win_overlay_match #(
  parameter int ROW_W = 5,
  parameter int COL_W = 6,
  parameter int SH_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ROW_W-1:0] row,
  input  logic [COL_W-1:0] col,
  input  logic [ROW_W-1:0] row_lo,
  input  logic [ROW_W-1:0] row_hi,
  input  logic [COL_W-1:0] col_lo,
  input  logic [COL_W-1:0] col_hi,
  input  logic [SH_W-1:0]  sh_w,
  input  logic [SH_W-1:0]  sh_h,
  input  logic             en,
  input  logic             sen,
  output logic             hit_body,
  output logic             hit_shadow
);
  localparam int RX_W = ROW_W + 1;
  localparam int CX_W = COL_W + 1;

  logic            shape_ok;
  logic            in_row, in_col;
  logic [RX_W-1:0] srow_lo, srow_hi, row_x;
  logic [CX_W-1:0] scol_lo, scol_hi, col_x;
  logic            in_srow, in_scol;

  always_comb begin
    shape_ok = en && (row_lo <= row_hi) && (col_lo <= col_hi);
    in_row   = (row >= row_lo) && (row <= row_hi);
    in_col   = (col >= col_lo) && (col <= col_hi);
    hit_body = shape_ok && in_row && in_col;

    // shadow box: window shifted right/down, computed one bit wider so it never wraps
    row_x   = {1'b0, row};
    col_x   = {1'b0, col};
    srow_lo = {1'b0, row_lo} + RX_W'(sh_h);
    srow_hi = {1'b0, row_hi} + RX_W'(sh_h);
    scol_lo = {1'b0, col_lo} + CX_W'(sh_w);
    scol_hi = {1'b0, col_hi} + CX_W'(sh_w);
    in_srow = (row_x >= srow_lo) && (row_x <= srow_hi);
    in_scol = (col_x >= scol_lo) && (col_x <= scol_hi);
    hit_shadow = shape_ok && sen && in_srow && in_scol && !hit_body;
  end

  // R6: a cell is never both body and shadow of the same window
  a_r6_body_shadow_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit_body && hit_shadow));
endmodule

// File: rtl/win_overlay_arb.sv
module win_overlay_arb #(
  parameter int NWIN  = 4,
  parameter int RGB_W = 3,
  parameter int IDX_W = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NWIN-1:0]            body,
  input  logic [NWIN-1:0]            shade,
  input  logic [NWIN-1:0][RGB_W-1:0] rgb_in,
  output logic                       active,
  output logic                       shadow,
  output logic [RGB_W-1:0]           rgb,
  output logic [IDX_W-1:0]           idx
);
  logic [NWIN-1:0] claim, grant;

  always_comb begin
    claim = body | shade;
    grant = '0;
    // scan from lowest priority up so the lowest index is written last
    for (int k = NWIN - 1; k >= 0; k--) begin
      if (claim[k]) begin
        grant    = '0;
        grant[k] = 1'b1;
      end
    end
    active = |claim;
    shadow = |(grant & shade);
    idx    = '0;
    rgb    = '0;
    for (int k = 0; k < NWIN; k++) begin
      if (grant[k]) begin
        idx = IDX_W'(k);
        if (!shade[k]) rgb = rgb_in[k];
      end
    end
  end

  // R5/R7: exactly one winner whenever any window claims the cell
  a_r5_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && ((grant != '0) == (claim != '0)));
endmodule

// File: rtl/win_overlay_ctrl.sv
module win_overlay_ctrl
  import win_overlay_pkg::*;
#(
  parameter int NWIN   = 4,
  parameter int ROW_W  = 5,
  parameter int COL_W  = 6,
  parameter int SH_W   = 2,
  parameter int RGB_W  = 3,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic [ADDR_W-1:0]       cfg_addr,
  input  logic [DATA_W-1:0]       cfg_wdata,
  input  logic                    pos_valid,
  output logic                    pos_ready,
  input  logic [ROW_W-1:0]        pos_row,
  input  logic [COL_W-1:0]        pos_col,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic                    out_active,
  output logic                    out_shadow,
  output logic [RGB_W-1:0]        out_rgb,
  output logic [$clog2(NWIN)-1:0] out_idx
);
  localparam int IDX_W = $clog2(NWIN);

  logic [NWIN-1:0][ROW_W-1:0] row_lo, row_hi;
  logic [NWIN-1:0][COL_W-1:0] col_lo, col_hi;
  logic [NWIN-1:0][SH_W-1:0]  sh_w, sh_h;
  logic [NWIN-1:0]            en, sen, body, shade;
  logic [NWIN-1:0][RGB_W-1:0] rgb;
  logic                       c_active, c_shadow;
  logic [RGB_W-1:0]           c_rgb;
  logic [IDX_W-1:0]           c_idx;

  win_overlay_regs #(
    .NWIN(NWIN), .ROW_W(ROW_W), .COL_W(COL_W), .SH_W(SH_W),
    .RGB_W(RGB_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .row_lo(row_lo), .row_hi(row_hi), .col_lo(col_lo), .col_hi(col_hi),
    .sh_w(sh_w), .sh_h(sh_h), .en(en), .sen(sen), .rgb(rgb)
  );

  for (genvar k = 0; k < NWIN; k++) begin : g_match
    win_overlay_match #(.ROW_W(ROW_W), .COL_W(COL_W), .SH_W(SH_W)) u_match (
      .clk(clk), .rst_n(rst_n), .row(pos_row), .col(pos_col),
      .row_lo(row_lo[k]), .row_hi(row_hi[k]),
      .col_lo(col_lo[k]), .col_hi(col_hi[k]),
      .sh_w(sh_w[k]), .sh_h(sh_h[k]), .en(en[k]), .sen(sen[k]),
      .hit_body(body[k]), .hit_shadow(shade[k])
    );
  end

  win_overlay_arb #(.NWIN(NWIN), .RGB_W(RGB_W), .IDX_W(IDX_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .body(body), .shade(shade), .rgb_in(rgb),
    .active(c_active), .shadow(c_shadow), .rgb(c_rgb), .idx(c_idx)
  );

  // single-entry output stage
  assign pos_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_active <= 1'b0;
      out_shadow <= 1'b0;
      out_rgb    <= '0;
      out_idx    <= '0;
    end else if (pos_ready) begin
      out_valid <= pos_valid;
      if (pos_valid) begin
        out_active <= c_active;
        out_shadow <= c_shadow;
        out_rgb    <= c_rgb;
        out_idx    <= c_idx;
      end
    end
  end

  // R1: an accepted position yields a result after the same edge
  a_r1_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_valid && pos_ready) |=> out_valid);

  // R2: a stalled result is held unchanged
  a_r2_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable({out_active, out_shadow, out_rgb, out_idx})));

  // R11: an unclaimed cell reports all-zero attributes
  a_r11_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_active) |-> (!out_shadow && out_rgb == '0 && out_idx == '0));

  // R6: a shadow result is black and counts as active
  a_r6_shadow_black: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_shadow) |-> (out_active && out_rgb == '0));
endmodule

// File: tb/tb_win_overlay_ctrl.sv
module tb_win_overlay_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [4:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic       pos_valid = 1'b0;
  logic       pos_ready;
  logic [4:0] pos_row = '0;
  logic [5:0] pos_col = '0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic       out_active, out_shadow;
  logic [2:0] out_rgb;
  logic [1:0] out_idx;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // bench-side model of the register contents
  int m_rlo[4], m_rhi[4], m_clo[4], m_chi[4], m_sw[4], m_sh[4], m_attr[4];

  always #2 clk = ~clk;

  win_overlay_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .pos_valid(pos_valid), .pos_ready(pos_ready),
    .pos_row(pos_row), .pos_col(pos_col), .out_valid(out_valid),
    .out_ready(out_ready), .out_active(out_active), .out_shadow(out_shadow),
    .out_rgb(out_rgb), .out_idx(out_idx)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 5'(a); cfg_wdata = 8'(d);
    @(negedge clk);
    cfg_we = 1'b0;
    if (a < 16) begin
      case (a % 4)
        0: m_rlo[a/4] = d & 31;
        1: m_rhi[a/4] = d & 31;
        2: m_clo[a/4] = d & 63;
        default: m_chi[a/4] = d & 63;
      endcase
    end else if (a == 16) begin
      for (int k = 0; k < 4; k++) m_sw[k] = (d >> (2*k)) & 3;
    end else if (a == 17) begin
      for (int k = 0; k < 4; k++) m_sh[k] = (d >> (2*k)) & 3;
    end else if (a < 22) begin
      m_attr[a-18] = d & 31;
    end
  endtask

  // expected {active, shadow, rgb[2:0], idx[1:0]}
  function automatic int model(input int r, input int c);
    for (int k = 0; k < 4; k++) begin
      bit ok, bd, sd;
      ok = (m_attr[k] & 1) && m_rlo[k] <= m_rhi[k] && m_clo[k] <= m_chi[k];
      bd = ok && r >= m_rlo[k] && r <= m_rhi[k] && c >= m_clo[k] && c <= m_chi[k];
      sd = ok && ((m_attr[k] >> 1) & 1) && !bd &&
           r >= m_rlo[k] + m_sh[k] && r <= m_rhi[k] + m_sh[k] &&
           c >= m_clo[k] + m_sw[k] && c <= m_chi[k] + m_sw[k];
      if (bd) return (1 << 6) | (((m_attr[k] >> 2) & 7) << 2) | k;
      if (sd) return (1 << 6) | (1 << 5) | k;
    end
    return 0;
  endfunction

  function automatic int result();
    return {25'd0, out_active, out_shadow, out_rgb, out_idx};
  endfunction

  task automatic probe(input int r, input int c, input string req);
    @(negedge clk);
    pos_valid = 1'b1; pos_row = 5'(r); pos_col = 6'(c); out_ready = 1'b1;
    @(negedge clk);
    pos_valid = 1'b0;
    check({req, " valid"}, int'(out_valid), 1);
    check(req, result(), model(r, c));
  endtask

  task automatic t_reset();
    check("R10 out_valid after reset", int'(out_valid), 0);
    check("R2 pos_ready when empty", int'(pos_ready), 1);
    probe(0, 0, "R10/R11 no window after reset");
    probe(31, 63, "R11 far corner idle");
  endtask

  task automatic t_basic();
    wr(0, 2); wr(1, 5); wr(2, 3); wr(3, 10);
    wr(18, (5 << 2) | 1);
    probe(2, 3, "R3 top-left corner");
    probe(5, 10, "R3 bottom-right corner");
    probe(4, 7, "R3 interior");
    probe(1, 3, "R3 above");
    probe(6, 10, "R3 below");
    probe(2, 2, "R3 left");
    probe(2, 11, "R3 right");
  endtask

  task automatic t_disabled();
    wr(4, 0); wr(5, 31); wr(6, 0); wr(7, 63);
    wr(19, (2 << 2) | 2);
    probe(20, 40, "R4 disabled window");
    wr(8, 10); wr(9, 8); wr(10, 0); wr(11, 63);
    wr(20, (3 << 2) | 3);
    probe(9, 20, "R4 row start beyond end");
    wr(8, 0); wr(9, 31); wr(10, 20); wr(11, 19);
    probe(9, 20, "R4 column start beyond end");
    wr(20, 0);
  endtask

  task automatic t_priority();
    wr(4, 4); wr(5, 8); wr(6, 8); wr(7, 15);
    wr(19, (2 << 2) | 1);
    wr(12, 4); wr(13, 8); wr(14, 8); wr(15, 15);
    wr(21, (7 << 2) | 1);
    probe(4, 9, "R5 window 0 over 1 and 3");
    probe(7, 12, "R5 window 1 over 3");
    wr(19, 0);
    probe(7, 12, "R5 window 3 alone");
    wr(21, 0);
  endtask

  task automatic t_shadow();
    wr(18, (5 << 2) | 3);
    wr(16, 8'h02); wr(17, 8'h01);
    probe(6, 5, "R6 shadow below");
    probe(6, 4, "R6 left of shadow");
    probe(3, 12, "R6 shadow right");
    probe(3, 11, "R6 shadow right edge");
    probe(7, 5, "R6 below shadow");
    probe(5, 10, "R6 body not shadow");
    probe(2, 11, "R6 notch above shadow");
  endtask

  task automatic t_shadow_prio();
    wr(19, (2 << 2) | 1);
    probe(6, 9, "R7 window 0 shadow over window 1 body");
    wr(21, (7 << 2) | 3);
    wr(16, 8'h42); wr(17, 8'h41);
    probe(9, 12, "R7 window 3 shadow");
    wr(8, 9); wr(9, 9); wr(10, 12); wr(11, 12);
    wr(20, (4 << 2) | 1);
    probe(9, 12, "R7 window 2 body over window 3 shadow");
    probe(9, 13, "R7 window 3 shadow beside");
  endtask

  task automatic t_no_shadow();
    wr(16, 8'h40); wr(17, 8'h40);
    probe(6, 5, "R8 zero offsets give no shadow");
    wr(21, (7 << 2) | 1);
    probe(9, 13, "R8 shadow enable cleared");
  endtask

  task automatic t_unmapped();
    wr(22, 8'hFF); wr(31, 8'hFF); wr(25, 8'h00);
    probe(6, 9, "R9 unmapped write ignored");
    probe(4, 9, "R9 window 0 unchanged");
    probe(9, 12, "R9 window 2 unchanged");
  endtask

  task automatic t_stall();
    @(negedge clk);
    out_ready = 1'b0; pos_valid = 1'b1; pos_row = 5'd4; pos_col = 6'd9;
    @(negedge clk);
    check("R1 valid one cycle after accept", int'(out_valid), 1);
    check("R1 first result", result(), model(4, 9));
    pos_row = 5'd7; pos_col = 6'd12;
    @(negedge clk);
    check("R2 ready low while stalled", int'(pos_ready), 0);
    check("R2 result held", result(), model(4, 9));
    check("R2 valid held", int'(out_valid), 1);
    out_ready = 1'b1;
    @(negedge clk);
    check("R2 next result after release", result(), model(7, 12));
    pos_valid = 1'b0;
    @(negedge clk);
    check("R2 drained", int'(out_valid), 0);
  endtask

  initial begin
    for (int k = 0; k < 4; k++) begin
      m_rlo[k] = 0; m_rhi[k] = 0; m_clo[k] = 0; m_chi[k] = 0;
      m_sw[k] = 0; m_sh[k] = 0; m_attr[k] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_disabled();
    t_priority();
    t_shadow();
    t_shadow_prio();
    t_no_shadow();
    t_unmapped();
    t_stall();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule